// File: doc/BRIEF.md
# Column Burst Staging Buffer

This block sits between the wide column path of a memory array bank and the narrow byte port of one memory device. A column address of ten bits is split in two parts. The upper six bits choose one of 64 slices, each 128 bits wide. The lower four bits choose the byte within that slice where a burst begins. A read request fetches the whole slice in a single array access. The block then streams sixteen bytes out, one per clock, starting at the chosen byte and wrapping around inside the slice.

A write request works the same way in the other direction, using its own staging register. The block takes in sixteen bytes from the port, placing each at the next byte position with the same wrap. Only after the sixteenth byte has arrived does it write the full slice back to the array in one access. The block handles one request at a time. While a burst is in progress, the ready output is low and any new request is ignored. Any single byte can still be reached by starting a burst at that byte, so access does not have to be sequential.

Top module: `burst_stage`

## Requirements
- R1: After reset, `req_ready` is 1 and `done`, `arr_rd_en`, `arr_wr_en` and `rd_valid` are 0.
- R2: The slice index put out on `arr_slice` for a fetch or a commit equals bits [9:4] of the accepted `req_col`.
- R3: A read request accepted on a clock edge (`req_valid`=1, `req_ready`=1, `req_write`=0) makes `arr_rd_en` high for exactly the next cycle. The full 128-bit `arr_rd_data` of that cycle is captured.
- R4: In the 16 cycles after the fetch cycle, `rd_valid` is 1. Beat i carries byte ((start+i) mod 16) of the captured slice, where start is `req_col[3:0]` and byte j is bits [8j+7:8j].
- R5: A burst whose start byte is not 0 wraps from byte 15 to byte 0. It still delivers exactly 16 beats.
- R6: During a write burst, each cycle with `wr_valid`=1 stores `wr_data` at byte ((start+n) mod 16), where n counts the bytes received so far. Cycles with `wr_valid`=0 store nothing, and so do bytes offered while idle.
- R7: `arr_wr_en` rises only in the cycle after the 16th write byte is accepted. It stays high for exactly one cycle, and `arr_wr_data` then holds all 16 collected bytes.
- R8: `req_ready` is 0 from the acceptance of a request until its burst finishes. A request presented while `req_ready` is 0 causes no fetch and leaves the running burst unchanged.
- R9: `done` pulses for one cycle: on the last read beat for a read, and on the commit cycle for a write.
- R10: After a burst finishes, `req_ready` is 1 again and a request for a different slice is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Burst request strobe |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_col | input | 10 | Column address: [9:4] slice, [3:0] start byte |
| req_ready | output | 1 | High when a request can be accepted |
| done | output | 1 | One-cycle end-of-burst pulse |
| arr_rd_en | output | 1 | Array slice fetch enable |
| arr_wr_en | output | 1 | Array slice commit enable |
| arr_slice | output | 6 | Slice index for array access |
| arr_rd_data | input | 128 | Slice contents from the array |
| arr_wr_data | output | 128 | Slice contents to the array |
| rd_valid | output | 1 | Read beat valid |
| rd_data | output | 8 | Read beat byte |
| wr_valid | input | 1 | Write beat valid |
| wr_data | input | 8 | Write beat byte |

## Verification
The assertions watch several things on every cycle. A fetch or commit must follow its request or its last byte. The slice index must match the accepted column. `done` and the commit enable must last one cycle, and fetch and commit must never overlap. Busy-time requests must never start a fetch. Only the bench scenarios can show that the right byte appears at each beat and that wrap-around is correct. They also show that gaps and idle-time bytes leave the write slice untouched, and that the committed slice holds the bytes in the right positions, as seen through the array model.

// File: rtl/burst_stage.sv
module burst_stage #(
  parameter int COLW  = 10,
  parameter int DW    = 8,
  parameter int BEATS = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic [COLW-1:0]               req_col,
  output logic                          req_ready,
  output logic                          done,
  output logic                          arr_rd_en,
  output logic                          arr_wr_en,
  output logic [COLW-$clog2(BEATS)-1:0] arr_slice,
  input  logic [DW*BEATS-1:0]           arr_rd_data,
  output logic [DW*BEATS-1:0]           arr_wr_data,
  output logic                          rd_valid,
  output logic [DW-1:0]                 rd_data,
  input  logic                          wr_valid,
  input  logic [DW-1:0]                 wr_data
);
  localparam int BIW = $clog2(BEATS);
  localparam int SW  = COLW - BIW;
  localparam int AW  = DW * BEATS;
  localparam logic [BIW-1:0] LAST = BIW'(BEATS - 1);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_RBURST, S_WCOL, S_WCOMMIT} state_t;

  state_t         state;
  logic [SW-1:0]  slice_q;
  logic [BIW-1:0] beat_q;
  logic [BIW-1:0] cnt_q;
  logic [AW-1:0]  rbuf;
  logic [AW-1:0]  wbuf;

  wire accept = req_valid && req_ready;
  wire last   = cnt_q == LAST;

  assign req_ready   = state == S_IDLE;
  assign arr_rd_en   = state == S_FETCH;
  assign arr_wr_en   = state == S_WCOMMIT;
  assign arr_slice   = slice_q;
  assign arr_wr_data = wbuf;
  assign rd_valid    = state == S_RBURST;
  assign rd_data     = rd_valid ? rbuf[beat_q*DW +: DW] : '0;
  assign done        = (rd_valid && last) || arr_wr_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      slice_q <= '0;
      beat_q  <= '0;
      cnt_q   <= '0;
      rbuf    <= '0;
      wbuf    <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          slice_q <= req_col[COLW-1:BIW];
          beat_q  <= req_col[BIW-1:0];
          cnt_q   <= '0;
          state   <= req_write ? S_WCOL : S_FETCH;
        end
        S_FETCH: begin
          rbuf  <= arr_rd_data;
          state <= S_RBURST;
        end
        S_RBURST: begin
          beat_q <= beat_q + 1'b1;
          cnt_q  <= cnt_q + 1'b1;
          if (last) state <= S_IDLE;
        end
        S_WCOL: if (wr_valid) begin
          wbuf[beat_q*DW +: DW] <= wr_data;
          beat_q <= beat_q + 1'b1;
          cnt_q  <= cnt_q + 1'b1;
          if (last) state <= S_WCOMMIT;
        end
        S_WCOMMIT: state <= S_IDLE;
        default:   state <= S_IDLE;
      endcase
    end
  end

  a_r3_fetch_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> arr_rd_en);
  a_r2_slice_from_column: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> arr_slice == $past(req_col[COLW-1:BIW]));
  a_r4_beats_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rd_en |=> rd_valid && !arr_rd_en);
  a_r7_commit_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_en |=> !arr_wr_en);
  a_r7_commit_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arr_wr_en) |-> $past(wr_valid));
  a_r8_busy_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> !arr_rd_en);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_rd_en && arr_wr_en));
endmodule

// File: tb/burst_stage_tb.sv
module burst_stage_tb;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         req_valid = 0, req_write = 0;
  logic [9:0]   req_col = '0;
  logic         req_ready, done, arr_rd_en, arr_wr_en, rd_valid;
  logic [5:0]   arr_slice;
  logic [127:0] arr_rd_data, arr_wr_data;
  logic [7:0]   rd_data;
  logic         wr_valid = 0;
  logic [7:0]   wr_data = '0;
  logic [127:0] mem [64];
  int checks = 0, failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  burst_stage u_dut (.clk, .rst_n, .req_valid, .req_write, .req_col, .req_ready, .done,
    .arr_rd_en, .arr_wr_en, .arr_slice, .arr_rd_data, .arr_wr_data,
    .rd_valid, .rd_data, .wr_valid, .wr_data);

  function automatic logic [7:0] seed_byte(int s, int k);
    return 8'(s * 37 + k * 11 + 5);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < 64; s++)
        for (int k = 0; k < 16; k++) mem[s][k*8 +: 8] <= seed_byte(s, k);
    end else if (arr_wr_en) mem[arr_slice] <= arr_wr_data;
  end
  assign arr_rd_data = mem[arr_slice];

  localparam logic [9:0] RD_COLS [8] = '{10'h000, 10'h00F, 10'h3F5, 10'h2A8,
                                         10'h151, 10'h07C, 10'h3FF, 10'h1E3};

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic read_burst(logic [9:0] col, bit poke_busy);
    logic [127:0] slice_val;
    @(negedge clk);
    chk(req_ready, "R10 ready before read", req_ready, 1);
    req_valid = 1; req_write = 0; req_col = col;
    @(negedge clk);
    req_valid = 0;
    slice_val = mem[col[9:4]];
    chk(arr_rd_en, "R3 fetch enable", arr_rd_en, 1);
    chk(arr_slice == col[9:4], "R2 fetch slice", arr_slice, col[9:4]);
    chk(!req_ready, "R8 busy in fetch", req_ready, 0);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (poke_busy && i == 3) begin req_valid = 1; req_write = 0; req_col = ~col; end
      if (poke_busy && i == 4) req_valid = 0;
      chk(rd_valid, "R4 beat valid", rd_valid, 1);
      chk(rd_data == slice_val[((col[3:0] + i) % 16) * 8 +: 8], "R4 R5 beat byte",
          rd_data, slice_val[((col[3:0] + i) % 16) * 8 +: 8]);
      chk(done == (i == 15), "R9 read done", done, i == 15);
      chk(!arr_rd_en, "R8 no fetch mid burst", arr_rd_en, 0);
    end
    @(negedge clk);
    chk(!rd_valid && req_ready && !arr_rd_en, "R10 idle after read", {rd_valid, req_ready, arr_rd_en}, 3'b010);
  endtask

  task automatic write_burst(logic [9:0] col, logic [7:0] base);
    logic [127:0] exp;
    exp = mem[col[9:4]];
    @(negedge clk);
    wr_valid = 1; wr_data = 8'hEE;
    @(negedge clk);
    wr_valid = 0;
    req_valid = 1; req_write = 1; req_col = col;
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready && !arr_rd_en, "R8 busy in write", {req_ready, arr_rd_en}, 0);
    for (int i = 0; i < 16; i++) begin
      if (i == 7) begin
        wr_valid = 0; wr_data = 8'h55;
        @(negedge clk);
        chk(!arr_wr_en, "R6 gap no commit", arr_wr_en, 0);
      end
      wr_valid = 1; wr_data = base + 8'(i);
      exp[((col[3:0] + i) % 16) * 8 +: 8] = base + 8'(i);
      @(negedge clk);
      if (i < 15) chk(!arr_wr_en, "R7 no early commit", arr_wr_en, 0);
    end
    wr_valid = 0;
    chk(arr_wr_en, "R7 commit", arr_wr_en, 1);
    chk(done, "R9 write done", done, 1);
    chk(arr_slice == col[9:4], "R2 commit slice", arr_slice, col[9:4]);
    chk(arr_wr_data == exp, "R6 R7 commit data", arr_wr_data, exp);
    @(negedge clk);
    chk(!arr_wr_en && !done && req_ready, "R7 single commit", {arr_wr_en, done, req_ready}, 3'b001);
    chk(mem[col[9:4]] == exp, "R7 array updated", mem[col[9:4]], exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !done && !arr_rd_en && !arr_wr_en && !rd_valid, "R1 reset state",
        {req_ready, done, arr_rd_en, arr_wr_en, rd_valid}, 5'b10000);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !rd_valid, "R1 after release", {req_ready, rd_valid}, 2'b10);
    foreach (RD_COLS[v]) read_burst(RD_COLS[v], 0);
    read_burst(10'h2B6, 1);
    write_burst(10'h09A, 8'h40);
    read_burst(10'h09A, 0);
    write_burst(10'h3F0, 8'hC0);
    read_burst(10'h3F0, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule